// File: doc/BRIEF.md
# Quasi-Bidirectional Port Bank

This block holds the output latches for a bank of general-purpose I/O ports that have no direction register. Each line is quasi-bidirectional. A latch bit of 0 turns on the line's pull-down and holds the pad low. A latch bit of 1 turns the pull-down off and releases the pad. On most ports a weak pull-up then raises the line. On the open-drain port nothing pulls the line up, so it floats unless an external source drives it. To use a line as an input, software writes 1 to its latch bit and then reads the pin level.

The internal bus side has two write paths. The first loads a whole port from a byte. The second sets or clears a single bit of one port without disturbing the other bits. The bus side can also read either a port's latch contents or its pin levels. Pin levels pass through a two-flop synchronizer before they reach the read path. With default parameters the block has four 8-bit ports, and port 0 is the open-drain port. All bank-wide vectors are packed with port p in bits [8p+7:8p].

The reset is asynchronous and active low. It must be released synchronously to `clk`. The read data is combinational from the selects and the registered state.

Top module: `qbd_port_bank`

## Requirements
- R1: While `rst_n` is low, every latch bit reads 1 and every synchronizer flop holds 1. As a result, `pad_pd_en` is all zeros and `pad_pu_en` is 1 on ports 1 to 3 and 0 on port 0.
- R2: When `port_we` is 1, the latch of port `port_sel` takes `port_wdata` at the next rising edge. A port that is not selected, and any port in a cycle with no write strobe, keeps its latch value. This holds whatever `port_wdata` carries.
- R3: When `bit_we` is 1, bit `bit_idx` of port `bit_port` takes `bit_val` at the next rising edge. All other bits of that latch keep their latch value, whatever the pin levels are.
- R4: If both strobes are active in one cycle and select the same port, the port load applies first and the single-bit update overrides the selected bit. If they select different ports, both updates take effect.
- R5: `pad_pd_en` is the bitwise inverse of the latch contents on every port.
- R6: `pad_pu_en` equals the latch contents on ports 1 to 3 and is always 0 on port 0, the open-drain port. No bit has both its pull-up and its pull-down enabled.
- R7: With `rd_pin` = 0, `rd_data` returns the latch of port `rd_sel`.
- R8: With `rd_pin` = 1, `rd_data` returns the `pad_in` bits of port `rd_sel` as they were sampled two rising edges earlier. A change on `pad_in` is not visible after one edge and is visible after the second.
- R9: A pin read reports the pin level regardless of the latch contents, even when the latch holds 0 and the pin is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| port_we | input | 1 | Whole-port write strobe |
| port_sel | input | 2 | Port targeted by the whole-port write |
| port_wdata | input | 8 | Byte loaded into the selected latch |
| bit_we | input | 1 | Single-bit write strobe |
| bit_port | input | 2 | Port targeted by the single-bit write |
| bit_idx | input | 3 | Bit position within that port |
| bit_val | input | 1 | Value written to the selected bit |
| rd_sel | input | 2 | Port selected for reading |
| rd_pin | input | 1 | 0 reads the latch, 1 reads the synchronized pins |
| rd_data | output | 8 | Read data |
| pad_in | input | 32 | Sampled pin levels, port p in bits [8p+7:8p] |
| pad_pd_en | output | 32 | Per-bit pull-down enable |
| pad_pu_en | output | 32 | Per-bit weak pull-up enable |

## Verification
The assertions assume that `rst_n` is released on a clock boundary. They also assume that `port_sel` and `bit_port` stay below the port count and that the write strobes carry defined values after reset. Under these conditions, a cycle with no strobe leaves every latch unchanged, and each synchronizer stage follows its predecessor one edge later. The stimulus changes inputs only on the falling clock edge and always keeps the selects within the four ports. It holds `pad_in` steady for at least two rising edges before any pin read it checks, except in the directed test that probes the two-edge latency on purpose.

// File: rtl/qbd_pkg.sv
package qbd_pkg;

  // Read source selector
  typedef enum logic {
    RD_SRC_LATCH = 1'b0,
    RD_SRC_PIN   = 1'b1
  } rd_src_e;

endpackage

// File: rtl/qbd_port_latch.sv
// One port's output latch with whole-port and single-bit write paths.
module qbd_port_latch #(
  parameter int W = 8,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_we,
  input  logic [W-1:0]     port_wdata,
  input  logic             bit_we,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             bit_val,
  output logic [W-1:0]     q
);

  logic [W-1:0] sel_mask;
  logic [W-1:0] q_nxt;
  logic         q_en;

  assign sel_mask = W'(1) << bit_idx;
  assign q_en     = port_we | bit_we;

  // Next-state: the port load first, then the bit update on top of it
  always_comb begin
    q_nxt = q;
    if (port_we) begin
      q_nxt = port_wdata;
    end
    if (bit_we) begin
      q_nxt = (q_nxt & ~sel_mask) | (bit_val ? sel_mask : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '1;
    end else if (q_en) begin
      q <= q_nxt;
    end
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_we || bit_we) |=> $stable(q));  // R2

  AST_PORT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (port_we && !bit_we) |=> (q == $past(port_wdata)));  // R2

  AST_BIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_we && !port_we) |=> (((q ^ $past(q)) & ~$past(sel_mask)) == '0));  // R3

  AST_BIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_we && port_we) |=> (((q ^ {W{$past(bit_val)}}) & $past(sel_mask)) == '0));  // R4

endmodule

// File: rtl/qbd_pin_sync.sv
// Two-flop synchronizer for one port's pin levels.
module qbd_pin_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] s1;
  logic [W-1:0] s1_nxt;
  logic [W-1:0] s2_nxt;

  always_comb begin
    s1_nxt = d;
    s2_nxt = s1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '1;
      q  <= '1;
    end else begin
      s1 <= s1_nxt;
      q  <= s2_nxt;
    end
  end

  AST_SYNC_STAGE1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (s1 == $past(d)));  // R8

  AST_SYNC_STAGE2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (q == $past(s1)));  // R8

endmodule

// File: rtl/qbd_pad_ctl.sv
// Pull-up and pull-down enables for one port derived from its latch.
module qbd_pad_ctl #(
  parameter int W          = 8,
  parameter bit OPEN_DRAIN = 1'b0
) (
  input  logic [W-1:0] lat,
  output logic [W-1:0] pd_en,
  output logic [W-1:0] pu_en
);

  assign pd_en = ~lat;

  generate
    if (OPEN_DRAIN) begin : g_od
      assign pu_en = '0;
    end else begin : g_qb
      assign pu_en = lat;
    end
  endgenerate

endmodule

// File: rtl/qbd_port_bank.sv
// Bank of quasi-bidirectional port latches with latch/pin read paths.
module qbd_port_bank #(
  parameter int                  N_PORTS = 4,
  parameter int                  PORT_W  = 8,
  parameter logic [N_PORTS-1:0]  OD_MASK = 4'b0001,
  localparam int PSEL_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int IDX_W  = (PORT_W > 1) ? $clog2(PORT_W) : 1,
  localparam int TOT_W  = N_PORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_we,
  input  logic [PSEL_W-1:0] port_sel,
  input  logic [PORT_W-1:0] port_wdata,
  input  logic              bit_we,
  input  logic [PSEL_W-1:0] bit_port,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              bit_val,
  input  logic [PSEL_W-1:0] rd_sel,
  input  logic              rd_pin,
  output logic [PORT_W-1:0] rd_data,
  input  logic [TOT_W-1:0]  pad_in,
  output logic [TOT_W-1:0]  pad_pd_en,
  output logic [TOT_W-1:0]  pad_pu_en
);

  import qbd_pkg::*;

  logic [PORT_W-1:0] lat_q [N_PORTS];
  logic [PORT_W-1:0] pin_q [N_PORTS];

  generate
    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      logic p_port_we;
      logic p_bit_we;

      assign p_port_we = port_we && (port_sel == PSEL_W'(p));
      assign p_bit_we  = bit_we  && (bit_port == PSEL_W'(p));

      qbd_port_latch #(.W(PORT_W)) u_lat (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_we    (p_port_we),
        .port_wdata (port_wdata),
        .bit_we     (p_bit_we),
        .bit_idx    (bit_idx),
        .bit_val    (bit_val),
        .q          (lat_q[p])
      );

      qbd_pin_sync #(.W(PORT_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in[p*PORT_W +: PORT_W]),
        .q     (pin_q[p])
      );

      qbd_pad_ctl #(.W(PORT_W), .OPEN_DRAIN(OD_MASK[p])) u_pad (
        .lat   (lat_q[p]),
        .pd_en (pad_pd_en[p*PORT_W +: PORT_W]),
        .pu_en (pad_pu_en[p*PORT_W +: PORT_W])
      );
    end
  endgenerate

  // Read mux: latch contents or synchronized pins
  always_comb begin
    if (rd_src_e'(rd_pin) == RD_SRC_PIN) begin
      rd_data = pin_q[rd_sel];
    end else begin
      rd_data = lat_q[rd_sel];
    end
  end

  AST_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu_en & pad_pd_en) == '0));  // R6

  AST_PD_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (port_we && !bit_we) |=> (pad_pd_en[$past(port_sel)*PORT_W +: PORT_W] == ~$past(port_wdata)));  // R5

  AST_PD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_we || bit_we) |=> $stable(pad_pd_en));  // R5

endmodule

// File: tb/sim_qbd_port_bank.sv
`timescale 1ns/1ps
module sim_qbd_port_bank;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        port_we;
  logic [1:0]  port_sel;
  logic [7:0]  port_wdata;
  logic        bit_we;
  logic [1:0]  bit_port;
  logic [2:0]  bit_idx;
  logic        bit_val;
  logic [1:0]  rd_sel;
  logic        rd_pin;
  logic [7:0]  rd_data;
  logic [31:0] pad_in;
  logic [31:0] pad_pd_en;
  logic [31:0] pad_pu_en;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  qbd_port_bank u0 (
    .clk(clk), .rst_n(rst_n),
    .port_we(port_we), .port_sel(port_sel), .port_wdata(port_wdata),
    .bit_we(bit_we), .bit_port(bit_port), .bit_idx(bit_idx), .bit_val(bit_val),
    .rd_sel(rd_sel), .rd_pin(rd_pin), .rd_data(rd_data),
    .pad_in(pad_in), .pad_pd_en(pad_pd_en), .pad_pu_en(pad_pu_en)
  );

  typedef struct packed {
    logic [15:0] tag;
    logic        pw;
    logic [1:0]  ps;
    logic [7:0]  wd;
    logic        bw;
    logic [1:0]  bp;
    logic [2:0]  bi;
    logic        bv;
    logic [1:0]  rs;
    logic        rp;
    logic [31:0] pad;
    logic [7:0]  exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{"R2", 1'b1, 2'd1, 8'h5A, 1'b0, 2'd0, 3'd0, 1'b0, 2'd1, 1'b0, 32'hFFFF_FFFF, 8'h5A},
    '{"R3", 1'b0, 2'd0, 8'h00, 1'b1, 2'd1, 3'd0, 1'b1, 2'd1, 1'b0, 32'hFFFF_FFFF, 8'h5B},
    '{"R3", 1'b0, 2'd0, 8'h00, 1'b1, 2'd2, 3'd7, 1'b0, 2'd2, 1'b0, 32'h0000_0000, 8'h7F},
    '{"R8", 1'b0, 2'd0, 8'h00, 1'b0, 2'd0, 3'd0, 1'b0, 2'd3, 1'b1, 32'h1234_5678, 8'h12},
    '{"R8", 1'b0, 2'd0, 8'h00, 1'b0, 2'd0, 3'd0, 1'b0, 2'd0, 1'b1, 32'h1234_5678, 8'h78},
    '{"R4", 1'b1, 2'd3, 8'h00, 1'b1, 2'd3, 3'd4, 1'b1, 2'd3, 1'b0, 32'h1234_5678, 8'h10},
    '{"R2", 1'b1, 2'd0, 8'h0F, 1'b0, 2'd0, 3'd0, 1'b0, 2'd3, 1'b0, 32'h1234_5678, 8'h10},
    '{"R7", 1'b0, 2'd0, 8'hAA, 1'b0, 2'd0, 3'd0, 1'b0, 2'd0, 1'b0, 32'h1234_5678, 8'h0F},
    '{"R9", 1'b0, 2'd0, 8'h00, 1'b0, 2'd0, 3'd0, 1'b0, 2'd1, 1'b1, 32'h0000_A500, 8'hA5},
    '{"R4", 1'b1, 2'd2, 8'h33, 1'b1, 2'd1, 3'd6, 1'b0, 2'd1, 1'b0, 32'h0000_A500, 8'h1B}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    port_we = 1'b0; port_sel = '0; port_wdata = '0;
    bit_we = 1'b0; bit_port = '0; bit_idx = '0; bit_val = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    idle_inputs();
    rd_sel = '0; rd_pin = 1'b0; pad_in = '1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);

    // R1: reset state, sampled while reset is still held
    for (int p = 0; p < 4; p++) begin
      rd_sel = p[1:0]; rd_pin = 1'b0; #1;
      chk("R1 latch", {24'h0, rd_data}, 32'h0000_00FF);
    end
    chk("R1 pd", pad_pd_en, 32'h0000_0000);
    chk("R1 pu", pad_pu_en, 32'hFFFF_FF00);
    rst_n = 1'b1;

    // Vector table walk: one write cycle, then two settle edges
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      port_we = VEC[i].pw; port_sel = VEC[i].ps; port_wdata = VEC[i].wd;
      bit_we = VEC[i].bw; bit_port = VEC[i].bp; bit_idx = VEC[i].bi; bit_val = VEC[i].bv;
      rd_sel = VEC[i].rs; rd_pin = VEC[i].rp; pad_in = VEC[i].pad;
      @(negedge clk);
      idle_inputs();
      repeat (2) @(negedge clk);
      chk($sformatf("%s vector %0d", VEC[i].tag, i), {24'h0, rd_data}, {24'h0, VEC[i].exp});
    end

    // Latches now: p0=0F p1=1B p2=33 p3=10
    rd_sel = 2'd2; rd_pin = 1'b0; #1;
    chk("R4 other port", {24'h0, rd_data}, 32'h0000_0033);
    chk("R5 pd", pad_pd_en, ~32'h1033_1B0F);
    chk("R6 pu", pad_pu_en, 32'h1033_1B00);

    // R2: data bus activity without a strobe changes nothing
    @(negedge clk);
    port_wdata = 8'hC6; port_sel = 2'd2; bit_idx = 3'd1; bit_val = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 no strobe", pad_pd_en, ~32'h1033_1B0F);
    idle_inputs();

    // R8: two-edge latency on port 2 pins
    pad_in = 32'h0000_0000; rd_sel = 2'd2; rd_pin = 1'b1;
    repeat (3) @(negedge clk);
    pad_in = 32'h00C3_0000;
    @(negedge clk);
    chk("R8 after one edge", {24'h0, rd_data}, 32'h0000_0000);
    @(negedge clk);
    chk("R8 after two edges", {24'h0, rd_data}, 32'h0000_00C3);

    // R9: latch bit 0 but pin high still reads high
    @(negedge clk);
    bit_we = 1'b1; bit_port = 2'd3; bit_idx = 3'd4; bit_val = 1'b0;
    pad_in = 32'hFF00_0000; rd_sel = 2'd3; rd_pin = 1'b1;
    @(negedge clk);
    idle_inputs();
    repeat (2) @(negedge clk);
    chk("R9 pin over latch", {24'h0, rd_data}, 32'h0000_00FF);
    rd_pin = 1'b0; #1;
    chk("R3 latch cleared", {24'h0, rd_data}, 32'h0000_0000);
    chk("R6 open drain", {24'h0, pad_pu_en[7:0]}, 32'h0000_0000);

    // R1: reset in mid-run restores all latches
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 rereset pd", pad_pd_en, 32'h0000_0000);
    chk("R1 rereset pu", pad_pu_en, 32'hFFFF_FF00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    finish_run();
  end

endmodule